// File: doc/BRIEF.md
# Carry-Mode ALU with Selectable Condition

This block is a 32-bit integer ALU whose outputs are captured on the rising clock edge. Each cycle it accepts an opcode, a condition select, two operands and a reject strobe, and one cycle later presents a result word, a single condition bit, an error flag and the current carry flag. The add and subtract opcodes come in four families that differ only in how they consume and update the stored carry flag, which lets one datapath serve multi-word signed arithmetic, multi-word unsigned arithmetic, carry-transparent arithmetic and carry-clearing arithmetic.

The condition bit is computed from the operands, the raw arithmetic output and the carry-out of the same operation; it covers zero tests, signed ordering derived from carry and operand signs, overflow, carry state, an address-range test and a check on the 3-bit tag held in the top bits of each word. The carry flag is only updated when the cycle is not rejected and the selected condition is false, so an operation that traps or is squashed leaves the flag intact.

Top module: `cmode_alu`

## Requirements
- R1: After a synchronous reset, result, condition, error and carry outputs are all 0.
- R2: Outputs appear at the first clock edge after the inputs are applied. Opcodes: 0 SADD, 1 SSUB, 2 UADD, 3 USUB, 4 VADD, 5 VSUB, 6 LADD, 7 LSUB, 8 AND, 9 OR, 10 XOR, 11 BOUND. Subtraction yields left + ~right + ~cin and its reported carry c32 is the inverted adder carry-out; for addition c32 is the adder carry-out.
- R3: SADD/SSUB take the stored carry as cin and clear the carry flag.
- R4: UADD/USUB take the stored carry as cin and load c32 into the carry flag.
- R5: VADD/VSUB and LADD/LSUB ignore the stored carry (cin 0 for add, 1 for subtract); the V pair leaves the carry flag unchanged, the L pair clears it.
- R6: AND, OR, XOR give the bitwise result, report c32 = 0 and leave the carry flag unchanged.
- R7: BOUND outputs the left operand unchanged, evaluates the condition on left minus right (cin 1), and leaves the carry flag unchanged.
- R8: The carry flag keeps its value in any cycle where reject is high or the computed condition is true.
- R9: Selects 0 NEVER (always 0), 1 ZERO (arith output == 0), 5 NONZERO, 4 ADDRCHK (arith output below the kernel limit, default 0x0001_0000), 13 MODE (always 1).
- R10: LT (2) = c32 XOR sign(left) XOR sign(right); LE (3) = LT or zero; GE (6) = not LT; GT (7) = not LE.
- R11: OVF (8) = c32 XOR sign(output) XOR sign(left) XOR sign(right); BC (9) = not c32; NOTBC (11) = c32.
- R12: TAG (10) is true when bits 31:29 of left, right or the arithmetic output are neither 000 nor 111; NOTTAG (12) is its complement.
- R13: Opcodes 12-15 give result 0, arithmetic output 0, c32 0, hold the carry flag and raise the error flag; selects 14-15 give condition 0 and raise the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| sel_i | input | 4 | Condition select |
| left_i | input | 32 | Left operand |
| right_i | input | 32 | Right operand |
| reject_i | input | 1 | Squash carry update this cycle |
| result_o | output | 32 | Registered result |
| cond_o | output | 1 | Registered condition bit |
| err_o | output | 1 | Registered unused-code flag |
| carry_o | output | 1 | Committed carry flag |

## Verification
The assertions assume every input is a known value at each rising edge once reset is released and that the carry flag is reachable only through the operations themselves, so no property models an external load of the flag. The stimulus changes inputs only on falling edges, holds them stable across the sampling edge, and first drives the flag to a known 1 with an unsigned add overflow before each family test so the effect of the stored carry is visible. Reject and a true condition are each exercised on operations that would otherwise change the flag.

// File: rtl/cmode_alu_pkg.sv
package cmode_alu_pkg;

    localparam int TAG_W = 3;

    typedef enum logic [3:0] {
        OP_SADD = 4'd0,
        OP_SSUB = 4'd1,
        OP_UADD = 4'd2,
        OP_USUB = 4'd3,
        OP_VADD = 4'd4,
        OP_VSUB = 4'd5,
        OP_LADD = 4'd6,
        OP_LSUB = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_BND  = 4'd11
    } op_e;

    typedef enum logic [3:0] {
        CS_NEVER  = 4'd0,
        CS_ZERO   = 4'd1,
        CS_LT     = 4'd2,
        CS_LE     = 4'd3,
        CS_ADDR   = 4'd4,
        CS_NZ     = 4'd5,
        CS_GE     = 4'd6,
        CS_GT     = 4'd7,
        CS_OVF    = 4'd8,
        CS_BC     = 4'd9,
        CS_TAG    = 4'd10,
        CS_NBC    = 4'd11,
        CS_NTAG   = 4'd12,
        CS_MODE   = 4'd13
    } csel_e;

    function automatic logic tag_odd(input logic [TAG_W-1:0] t);
        return !((t == '0) || (t == '1));
    endfunction

    function automatic logic op_known(input logic [3:0] op);
        return op <= 4'd11;
    endfunction

endpackage

// File: rtl/cmode_alu_arith.sv
module cmode_alu_arith
    import cmode_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         carry_in,
    output logic [W-1:0] sum,
    output logic         c32,
    output logic         carry_nx
);
    logic         is_sub;
    logic         use_flag;
    logic         cin_raw;
    logic         cin_add;
    logic         cout;
    logic [W-1:0] rhs_eff;

    always_comb begin
        is_sub   = (op == OP_SSUB) || (op == OP_USUB) || (op == OP_VSUB) ||
                   (op == OP_LSUB) || (op == OP_BND);
        use_flag = (op == OP_SADD) || (op == OP_SSUB) ||
                   (op == OP_UADD) || (op == OP_USUB);
        cin_raw  = use_flag ? carry_in : 1'b0;
        cin_add  = is_sub ? ~cin_raw : cin_raw;
        rhs_eff  = is_sub ? ~rhs : rhs;
        {cout, sum} = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, cin_add};
        c32      = is_sub ? ~cout : cout;

        case (op)
            OP_SADD, OP_SSUB, OP_LADD, OP_LSUB: carry_nx = 1'b0;
            OP_UADD, OP_USUB:                   carry_nx = c32;
            default:                            carry_nx = carry_in;
        endcase
    end
endmodule

// File: rtl/cmode_alu_cond.sv
module cmode_alu_cond
    import cmode_alu_pkg::*;
#(
    parameter int          W     = 32,
    parameter logic [31:0] KLIM  = 32'h0001_0000
) (
    input  logic [3:0]   sel,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic [W-1:0] aout,
    input  logic         c32,
    output logic         cond,
    output logic         sel_bad
);
    logic zero, lt, le, ovf, tag;

    always_comb begin
        zero = (aout == '0);
        lt   = c32 ^ (lhs[W-1] ^ rhs[W-1]);
        le   = lt | zero;
        ovf  = (c32 ^ aout[W-1]) ^ (lhs[W-1] ^ rhs[W-1]);
        tag  = tag_odd(lhs[W-1 -: TAG_W]) | tag_odd(rhs[W-1 -: TAG_W]) |
               tag_odd(aout[W-1 -: TAG_W]);
        sel_bad = 1'b0;
        case (sel)
            CS_NEVER: cond = 1'b0;
            CS_ZERO:  cond = zero;
            CS_LT:    cond = lt;
            CS_LE:    cond = le;
            CS_ADDR:  cond = (aout < W'(KLIM));
            CS_NZ:    cond = ~zero;
            CS_GE:    cond = ~lt;
            CS_GT:    cond = ~le;
            CS_OVF:   cond = ovf;
            CS_BC:    cond = ~c32;
            CS_TAG:   cond = tag;
            CS_NBC:   cond = c32;
            CS_NTAG:  cond = ~tag;
            CS_MODE:  cond = 1'b1;
            default: begin
                cond    = 1'b0;
                sel_bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cmode_alu.sv
module cmode_alu
    import cmode_alu_pkg::*;
#(
    parameter int          W    = 32,
    parameter logic [31:0] KLIM = 32'h0001_0000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   op_i,
    input  logic [3:0]   sel_i,
    input  logic [W-1:0] left_i,
    input  logic [W-1:0] right_i,
    input  logic         reject_i,
    output logic [W-1:0] result_o,
    output logic         cond_o,
    output logic         err_o,
    output logic         carry_o
);
    logic [W-1:0] sum_w, aout_w, res_w;
    logic         c32_raw, c32_w, carry_nx_w, cond_w, sel_bad_w, op_ok;
    logic         carry_q;

    cmode_alu_arith #(.W(W)) u_arith (
        .op       (op_i),
        .lhs      (left_i),
        .rhs      (right_i),
        .carry_in (carry_q),
        .sum      (sum_w),
        .c32      (c32_raw),
        .carry_nx (carry_nx_w)
    );

    always_comb begin
        op_ok = op_known(op_i);
        c32_w = 1'b0;
        case (op_i)
            OP_AND:  aout_w = left_i & right_i;
            OP_OR:   aout_w = left_i | right_i;
            OP_XOR:  aout_w = left_i ^ right_i;
            default: begin
                aout_w = op_ok ? sum_w : '0;
                c32_w  = op_ok ? c32_raw : 1'b0;
            end
        endcase
        res_w = (op_i == OP_BND) ? left_i : aout_w;
    end

    cmode_alu_cond #(.W(W), .KLIM(KLIM)) u_cond (
        .sel     (sel_i),
        .lhs     (left_i),
        .rhs     (right_i),
        .aout    (aout_w),
        .c32     (c32_w),
        .cond    (cond_w),
        .sel_bad (sel_bad_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            cond_o   <= 1'b0;
            err_o    <= 1'b0;
            carry_q  <= 1'b0;
        end else begin
            result_o <= res_w;
            cond_o   <= cond_w;
            err_o    <= ~op_ok | sel_bad_w;
            if (!(reject_i || cond_w))
                carry_q <= carry_nx_w;
        end
    end

    assign carry_o = carry_q;

    assert_hold_on_reject_R8: assert property (@(posedge clk) disable iff (rst)
        reject_i |=> (carry_o == $past(carry_o)));

    assert_vpair_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        ((op_i == OP_VADD) || (op_i == OP_VSUB)) |=> $stable(carry_o));

    assert_clear_pairs_R3: assert property (@(posedge clk) disable iff (rst)
        (((op_i == OP_SADD) || (op_i == OP_SSUB) || (op_i == OP_LADD) ||
          (op_i == OP_LSUB)) && !reject_i && !cond_w) |=> !carry_o);

    assert_bound_passes_left_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_BND) |=> (result_o == $past(left_i)));

    assert_mode_true_R9: assert property (@(posedge clk) disable iff (rst)
        (sel_i == CS_MODE) |=> cond_o);

    assert_never_false_R9: assert property (@(posedge clk) disable iff (rst)
        (sel_i == CS_NEVER) |=> !cond_o);

    assert_bad_op_R13: assert property (@(posedge clk) disable iff (rst)
        (op_i > 4'd11) |=> (err_o && (result_o == '0) && $stable(carry_o)));
endmodule

// File: tb/sim_cmode_alu.sv
`timescale 1ns/1ps
module sim_cmode_alu;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_i, sel_i;
    logic [31:0] left_i, right_i;
    logic        reject_i;
    logic [31:0] result_o;
    logic        cond_o, err_o, carry_o;

    always #2.5 clk = ~clk;

    cmode_alu u0 (
        .clk(clk), .rst(rst), .op_i(op_i), .sel_i(sel_i),
        .left_i(left_i), .right_i(right_i), .reject_i(reject_i),
        .result_o(result_o), .cond_o(cond_o), .err_o(err_o), .carry_o(carry_o)
    );

    typedef struct {
        logic [31:0] res;
        logic        cnd;
        logic        err;
        logic        cry;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    logic m_carry = 1'b0;
    bit   done = 0;

    function automatic logic odd3(input logic [2:0] t);
        return (t != 3'b000) && (t != 3'b111);
    endfunction

    task automatic drive(input logic [3:0] op, input logic [3:0] sel,
                         input logic [31:0] l, input logic [31:0] r,
                         input logic rej, input string tag);
        exp_t e;
        logic [32:0] wide;
        logic [31:0] a;
        logic        c, brw, known, nc, lt, z, sbad, cnd;
        @(negedge clk);
        op_i = op; sel_i = sel; left_i = l; right_i = r; reject_i = rej;
        known = (op <= 4'd11);
        a = 32'd0; c = 1'b0; nc = m_carry;
        if (op == 4'd0 || op == 4'd2 || op == 4'd4 || op == 4'd6) begin
            wide = {1'b0, l} + {1'b0, r} + ((op <= 4'd2) ? {32'd0, m_carry} : 33'd0);
            a = wide[31:0]; c = wide[32];
        end else if (op == 4'd1 || op == 4'd3 || op == 4'd5 || op == 4'd7 || op == 4'd11) begin
            brw = (op <= 4'd3) ? m_carry : 1'b0;
            wide = {1'b0, l} - {1'b0, r} - {32'd0, brw};
            a = wide[31:0]; c = wide[32];
        end else if (op == 4'd8) a = l & r;
        else if (op == 4'd9) a = l | r;
        else if (op == 4'd10) a = l ^ r;
        if (op == 4'd0 || op == 4'd1 || op == 4'd6 || op == 4'd7) nc = 1'b0;
        if (op == 4'd2 || op == 4'd3) nc = c;
        z  = (a == 32'd0);
        lt = c ^ l[31] ^ r[31];
        sbad = 1'b0;
        case (sel)
            4'd0:  cnd = 1'b0;
            4'd1:  cnd = z;
            4'd2:  cnd = lt;
            4'd3:  cnd = lt | z;
            4'd4:  cnd = a < 32'h0001_0000;
            4'd5:  cnd = !z;
            4'd6:  cnd = !lt;
            4'd7:  cnd = !(lt | z);
            4'd8:  cnd = c ^ a[31] ^ l[31] ^ r[31];
            4'd9:  cnd = !c;
            4'd10: cnd = odd3(l[31:29]) | odd3(r[31:29]) | odd3(a[31:29]);
            4'd11: cnd = c;
            4'd12: cnd = !(odd3(l[31:29]) | odd3(r[31:29]) | odd3(a[31:29]));
            4'd13: cnd = 1'b1;
            default: begin cnd = 1'b0; sbad = 1'b1; end
        endcase
        if (!(rej || cnd)) m_carry = nc;
        e.res = (op == 4'd11) ? l : a;
        e.cnd = cnd;
        e.err = !known | sbad;
        e.cry = m_carry;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        exp_t e;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_run++;
            if (result_o !== e.res || cond_o !== e.cnd || err_o !== e.err || carry_o !== e.cry) begin
                n_fail++;
                $display("FAIL %s: got res=%h cond=%b err=%b carry=%b, expected res=%h cond=%b err=%b carry=%b",
                         e.tag, result_o, cond_o, err_o, carry_o, e.res, e.cnd, e.err, e.cry);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_i = 4'd0; sel_i = 4'd0; left_i = 0; right_i = 0; reject_i = 0;
        repeat (3) @(negedge clk);
        n_run++;
        if (result_o !== 0 || cond_o !== 0 || err_o !== 0 || carry_o !== 0) begin
            n_fail++;
            $display("FAIL R1: got %h %b %b %b, expected all zero", result_o, cond_o, err_o, carry_o);
        end
        rst = 1'b0;
        // R2 / R5: plain V add, flag 0
        drive(4'd4, 4'd0, 32'd5, 32'd7, 0, "R2 vadd");
        // R4: unsigned add overflow sets flag
        drive(4'd2, 4'd0, 32'hFFFF_FFFF, 32'd1, 0, "R4 uadd set");
        drive(4'd2, 4'd0, 32'd1, 32'd1, 0, "R4 uadd uses carry");
        drive(4'd2, 4'd0, 32'hFFFF_FFFF, 32'd1, 0, "R4 uadd set again");
        drive(4'd0, 4'd0, 32'd1, 32'd1, 0, "R3 sadd uses carry, clears");
        drive(4'd3, 4'd0, 32'd3, 32'd5, 0, "R4 usub borrow sets");
        drive(4'd1, 4'd0, 32'd10, 32'd3, 0, "R3 ssub uses carry, clears");
        drive(4'd3, 4'd0, 32'd3, 32'd5, 0, "R4 usub set");
        drive(4'd4, 4'd0, 32'd1, 32'd1, 0, "R5 vadd ignores carry keeps");
        drive(4'd5, 4'd0, 32'd9, 32'd4, 0, "R5 vsub ignores carry keeps");
        drive(4'd6, 4'd0, 32'd2, 32'd2, 0, "R5 ladd clears");
        // R8 reject and condition suppress update
        drive(4'd2, 4'd0, 32'hFFFF_FFFF, 32'd2, 1, "R8 reject holds");
        drive(4'd2, 4'd1, 32'hFFFF_FFFF, 32'd1, 0, "R8 cond holds");
        drive(4'd3, 4'd0, 32'd0, 32'd1, 0, "R4 usub set for lsub");
        drive(4'd7, 4'd0, 32'd8, 32'd3, 0, "R5 lsub clears");
        // R6 logical
        drive(4'd8, 4'd0, 32'hF0F0_1234, 32'h0FF0_FF00, 0, "R6 and");
        drive(4'd9, 4'd9, 32'hF000_0000, 32'h0000_000F, 0, "R6 or bc");
        drive(4'd10, 4'd0, 32'hAAAA_5555, 32'hFFFF_0000, 0, "R6 xor");
        // R7 bound check
        drive(4'd11, 4'd2, 32'd3, 32'd5, 0, "R7 bound lt");
        drive(4'd11, 4'd6, 32'd7, 32'd5, 0, "R7 bound ge");
        // R10 compares
        drive(4'd5, 4'd2, 32'hFFFF_FFFF, 32'd1, 0, "R10 lt neg");
        drive(4'd5, 4'd3, 32'd4, 32'd4, 0, "R10 le equal");
        drive(4'd5, 4'd7, 32'd4, 32'd4, 0, "R10 gt equal");
        drive(4'd5, 4'd7, 32'd9, 32'hFFFF_FFF0, 0, "R10 gt pos");
        drive(4'd5, 4'd6, 32'h8000_0000, 32'd1, 0, "R10 ge min");
        // R11
        drive(4'd4, 4'd8, 32'h7FFF_FFFF, 32'd1, 0, "R11 ovf add");
        drive(4'd5, 4'd8, 32'h8000_0000, 32'd1, 0, "R11 ovf sub");
        drive(4'd4, 4'd8, 32'd1, 32'd1, 0, "R11 no ovf");
        drive(4'd5, 4'd11, 32'd1, 32'd2, 0, "R11 notbc");
        drive(4'd5, 4'd9, 32'd1, 32'd2, 0, "R11 bc");
        // R9
        drive(4'd4, 4'd4, 32'h100, 32'h200, 0, "R9 addr below");
        drive(4'd4, 4'd4, 32'h0001_0000, 32'd0, 0, "R9 addr at limit");
        drive(4'd4, 4'd5, 32'd1, 32'd2, 0, "R9 nonzero");
        drive(4'd4, 4'd13, 32'd0, 32'd0, 0, "R9 mode");
        drive(4'd8, 4'd1, 32'h0F, 32'hF0, 0, "R9 zero");
        // R12
        drive(4'd8, 4'd10, 32'h2000_0000, 32'hFFFF_FFFF, 0, "R12 tag left");
        drive(4'd9, 4'd12, 32'h1234_5678, 32'h0000_FFFF, 0, "R12 nottag");
        drive(4'd4, 4'd10, 32'h1FFF_FFFF, 32'd1, 0, "R12 tag result");
        // R13
        drive(4'd2, 4'd0, 32'hFFFF_FFFF, 32'd1, 0, "R4 set before bad op");
        drive(4'd13, 4'd0, 32'd5, 32'd6, 0, "R13 bad op");
        drive(4'd4, 4'd15, 32'd5, 32'd6, 0, "R13 bad sel");
        @(negedge clk);
        op_i = 4'd0; sel_i = 4'd0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule